// File: doc/BRIEF.md
# Coprocessor Operand Ordering Unit

This block sits between the integer core and two attached coprocessors. It forwards operand transfers from the core. Each transfer names one coprocessor and carries a small age tag that identifies its instruction. The core produces transfers in execution order, which can differ from program order. Each coprocessor port has its own ordering control bit, and software can change that bit at run time.

When a port's ordering bit is clear and that port holds nothing in its buffer, transfers pass straight through in arrival order. The coprocessor then uses the age tag to match data to instructions. When the bit is set, transfers for that port go into a small reorder store. They leave it strictly in program order. A per-port counter holds the next age to be released, and each release increments it by one.

Ages count per coprocessor, wrap modulo the tag range, and are compared only for equality with that counter. A flush input empties both stores and reloads each counter from a restart age that the core supplies. Software should issue a flush when it turns ordering on, so that the counter matches the next transfer.

Top module: `copro_feed_order`

## Requirements
- R1: A transfer with `in_dest` = k (0 or 1) appears only on port k, with its age and data unchanged.
- R2: When port k's ordering bit is clear and its store is empty, a transfer for port k shows on `cp_valid[k]` in the same cycle. In that case `in_ready` equals `cp_ready[k]`, so transfers leave in arrival order.
- R3: When port k's ordering bit is set, its transfers are stored and appear no earlier than the next cycle. A stored transfer is presented only when its age equals port k's expected age. Each release increments the expected age by one.
- R4: The expected age wraps from 2^AGE_W-1 to 0.
- R5: Each port stores at most DEPTH transfers. While port k's store is full, `in_ready` is low for transfers addressed to port k.
- R6: In a flush cycle, `in_ready` and every `cp_valid` bit are low. After the flush, both stores are empty and each port's expected age equals its field of `restart_age` (port k at bits k*AGE_W upward).
- R7: If the ordering bit is cleared while the store still holds transfers, those transfers keep draining in program order. New transfers for that port stall until the store is empty.
- R8: A presented stored transfer keeps `cp_valid` high and its age and data stable until the port accepts it.
- R9: Each port's ordering bit and store state affect only that port. The other port keeps passing traffic.
- R10: After reset, both stores are empty, no port is valid, and both expected ages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| order_en | input | NUM_CP | Per-port program-order enable |
| flush | input | 1 | Discard stored transfers and reload expected ages |
| restart_age | input | NUM_CP*AGE_W | Per-port expected age loaded on flush |
| in_valid | input | 1 | Transfer offered by the core |
| in_ready | output | 1 | Transfer accepted |
| in_dest | input | $clog2(NUM_CP) | Destination coprocessor port |
| in_age | input | AGE_W | Age tag of the transfer |
| in_data | input | DATA_W | Operand data |
| cp_valid | output | NUM_CP | Per-port transfer valid |
| cp_ready | input | NUM_CP | Per-port transfer accepted |
| cp_age | output | NUM_CP*AGE_W | Per-port age tag |
| cp_data | output | NUM_CP*DATA_W | Per-port operand data |

## Verification
The ordered port receives ages in reverse and in scrambled order. Reordering is observable only in that case: a design that passed data through would release the ages in arrival order. A run that starts close to the top of the age range checks that the expected age wraps correctly. The port is also filled while the coprocessor stalls, which checks that the store is full at exactly DEPTH transfers and that the presented entry stays stable. A pass-through port that is stalled and then released, compared with the ordered port running in parallel, shows that the two ports do not affect each other. Clearing the ordering bit while the store holds transfers checks that the store drains before pass-through traffic resumes, and that a flush cuts off an offer that is pending in that cycle.

// File: rtl/cpo_pkg.sv
package cpo_pkg;

   // Which path a lane presents on its output this cycle
   typedef enum logic {
      LANE_PASS     = 1'b0,
      LANE_BUFFERED = 1'b1
   } lane_path_e;

endpackage

// File: rtl/cpo_first_set.sv
// Lowest-index set bit finder, used for free-slot and age-match selection.
module cpo_first_set #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   initial assert (N >= 2 && (1 << IDX_W) >= N)
      else $fatal(1, "cpo_first_set: IDX_W too small for N");

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/cpo_lane.sv
// One coprocessor port: pass-through path plus an age-matched reorder store.
module cpo_lane
   import cpo_pkg::*;
#(
   parameter int AGE_W  = 4,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              order_en,
   input  logic              flush,
   input  logic [AGE_W-1:0]  restart_age,
   input  logic              wr_valid,
   input  logic [AGE_W-1:0]  wr_age,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [AGE_W-1:0]  out_age,
   output logic [DATA_W-1:0] out_data
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial assert (DEPTH >= 2 && DEPTH < (1 << AGE_W))
      else $fatal(1, "cpo_lane: DEPTH must be at least 2 and below the age range");

   logic [DEPTH-1:0]  slot_vld;
   logic [AGE_W-1:0]  slot_age [DEPTH];
   logic [DATA_W-1:0] slot_dat [DEPTH];
   logic [AGE_W-1:0]  exp_age;
   logic [AGE_W-1:0]  age_after;

   logic [DEPTH-1:0]  match_vec;
   logic [DEPTH-1:0]  free_vec;
   logic              hit;
   logic              has_free;
   logic [IDX_W-1:0]  hit_idx;
   logic [IDX_W-1:0]  free_idx;
   lane_path_e        path;
   logic              rel_fire;
   logic              store_fire;

   // Per-slot compare against the next program-order age
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      assign match_vec[s] = slot_vld[s] && (slot_age[s] == exp_age);
      assign free_vec[s]  = ~slot_vld[s];
   end

   cpo_first_set #(.N(DEPTH), .IDX_W(IDX_W)) u_match (
      .req   (match_vec),
      .found (hit),
      .idx   (hit_idx)
   );

   cpo_first_set #(.N(DEPTH), .IDX_W(IDX_W)) u_free (
      .req   (free_vec),
      .found (has_free),
      .idx   (free_idx)
   );

   // A non-empty store keeps the lane on the buffered path until drained
   assign path = (order_en || (|slot_vld)) ? LANE_BUFFERED : LANE_PASS;

   always_comb begin
      case (path)
         LANE_PASS: begin
            out_valid = wr_valid && !flush;
            out_age   = wr_age;
            out_data  = wr_data;
            wr_ready  = out_ready && !flush;
         end
         default: begin
            out_valid = hit && !flush;
            out_age   = slot_age[hit_idx];
            out_data  = slot_dat[hit_idx];
            wr_ready  = !flush && order_en && has_free;
         end
      endcase
   end

   assign rel_fire   = (path == LANE_BUFFERED) && out_valid && out_ready;
   assign store_fire = (path == LANE_BUFFERED) && wr_valid && wr_ready;
   assign age_after  = out_age + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_vld <= '0;
         exp_age  <= '0;
      end else if (flush) begin
         slot_vld <= '0;
         exp_age  <= restart_age;
      end else begin
         if (rel_fire) begin
            slot_vld[hit_idx] <= 1'b0;
            exp_age           <= age_after;
         end
         if (store_fire) begin
            slot_vld[free_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (store_fire) begin
         slot_age[free_idx] <= wr_age;
         slot_dat[free_idx] <= wr_data;
      end
   end

   // R3: every ordered release moves the expected age one step past it
   a_r3_age_advance : assert property (@(posedge clk) disable iff (!rst_n)
      rel_fire |=> (exp_age == $past(age_after)));

   // R6: flush empties the store and reloads the expected age
   a_r6_flush_reload : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ((slot_vld == '0) && (exp_age == $past(restart_age))));

   // R5: a store never happens into a full lane
   a_r5_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      store_fire |-> !(&slot_vld));

   // R7: with ordering off but entries left, new input is held back
   a_r7_drain_first : assert property (@(posedge clk) disable iff (!rst_n)
      (!order_en && (|slot_vld)) |-> !wr_ready);

   // R8: a presented stored transfer is held until taken
   a_r8_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
      ((path == LANE_BUFFERED) && out_valid && !out_ready) |=>
         (flush || (out_valid && $stable(out_age) && $stable(out_data))));

endmodule

// File: rtl/copro_feed_order.sv
// Top: routes core transfers to NUM_CP coprocessor lanes.
module copro_feed_order #(
   parameter int NUM_CP = 2,
   parameter int AGE_W  = 4,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   parameter int SEL_W  = (NUM_CP > 1) ? $clog2(NUM_CP) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CP-1:0]        order_en,
   input  logic                     flush,
   input  logic [NUM_CP*AGE_W-1:0]  restart_age,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [SEL_W-1:0]         in_dest,
   input  logic [AGE_W-1:0]         in_age,
   input  logic [DATA_W-1:0]        in_data,
   output logic [NUM_CP-1:0]        cp_valid,
   input  logic [NUM_CP-1:0]        cp_ready,
   output logic [NUM_CP*AGE_W-1:0]  cp_age,
   output logic [NUM_CP*DATA_W-1:0] cp_data
);

   initial assert (NUM_CP >= 2 && (1 << SEL_W) >= NUM_CP && AGE_W >= 2 && DATA_W >= 1)
      else $fatal(1, "copro_feed_order: parameter set out of range");

   logic [NUM_CP-1:0] lane_wr_valid;
   logic [NUM_CP-1:0] lane_wr_ready;
   logic [NUM_CP-1:0] lane_take;

   for (genvar k = 0; k < NUM_CP; k++) begin : g_lane
      assign lane_wr_valid[k] = in_valid && (in_dest == SEL_W'(k));
      assign lane_take[k]     = lane_wr_valid[k] && lane_wr_ready[k];

      cpo_lane #(
         .AGE_W  (AGE_W),
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH)
      ) u_lane (
         .clk         (clk),
         .rst_n       (rst_n),
         .order_en    (order_en[k]),
         .flush       (flush),
         .restart_age (restart_age[k*AGE_W +: AGE_W]),
         .wr_valid    (lane_wr_valid[k]),
         .wr_age      (in_age),
         .wr_data     (in_data),
         .wr_ready    (lane_wr_ready[k]),
         .out_valid   (cp_valid[k]),
         .out_ready   (cp_ready[k]),
         .out_age     (cp_age[k*AGE_W +: AGE_W]),
         .out_data    (cp_data[k*DATA_W +: DATA_W])
      );
   end

   always_comb begin
      in_ready = 1'b0;
      for (int k = 0; k < NUM_CP; k++) begin
         if (in_dest == SEL_W'(k)) in_ready = lane_wr_ready[k];
      end
   end

   // R1: a transfer is taken by at most one lane
   a_r1_single_lane : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_take));

   // R1: an accepted transfer was taken by the addressed lane
   a_r1_route_take : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> ($countones(lane_take) == 1));

   // R6: nothing moves in a flush cycle
   a_r6_flush_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!in_ready && (cp_valid == '0)));

endmodule

// File: tb/test_copro_feed_order.sv
module test_copro_feed_order;

   localparam int AW = 4;
   localparam int DW = 32;
   localparam int DP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    order_en = '0;
   logic          flush = 1'b0;
   logic [7:0]    restart_age = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [0:0]    in_dest = '0;
   logic [3:0]    in_age = '0;
   logic [31:0]   in_data = '0;
   logic [1:0]    cp_valid;
   logic [1:0]    cp_ready = '0;
   logic [7:0]    cp_age;
   logic [63:0]   cp_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int cycles = 0;

   // Reference model state
   int          qa [2][$];
   logic [31:0] qd [2][$];
   int          ex [2];
   bit          m_bufm [2];
   bit          m_rel [2];
   int          m_hit [2];
   bit          m_take;

   copro_feed_order #(.NUM_CP(2), .AGE_W(AW), .DATA_W(DW), .DEPTH(DP)) i_copro_feed_order (
      .clk         (clk),
      .rst_n       (rst_n),
      .order_en    (order_en),
      .flush       (flush),
      .restart_age (restart_age),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_dest     (in_dest),
      .in_age      (in_age),
      .in_data     (in_data),
      .cp_valid    (cp_valid),
      .cp_ready    (cp_ready),
      .cp_age      (cp_age),
      .cp_data     (cp_data)
   );

   always #10 clk = ~clk;

   task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] expv);
      checks++;
      if (got !== expv) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
      end
   endtask

   // Cycle model: compare combinational outputs before each rising edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         bit  evl;
         int  d;
         bit  erdy;
         string tg;
         for (int k = 0; k < 2; k++) begin
            m_hit[k] = -1;
            for (int i = 0; i < qa[k].size(); i++) if (qa[k][i] == ex[k]) m_hit[k] = i;
            m_bufm[k] = order_en[k] || (qa[k].size() != 0);
            if (flush) evl = 1'b0;
            else if (m_bufm[k]) evl = (m_hit[k] >= 0);
            else evl = in_valid && (int'(in_dest) == k);
            tg = flush ? "R6" : (!m_bufm[k] ? "R2" : (!order_en[k] ? "R7" : "R3"));
            chk(tg, $sformatf("cp_valid[%0d]", k), 64'(cp_valid[k]), 64'(evl));
            if (evl) begin
               if (m_bufm[k]) begin
                  chk("R3", $sformatf("cp_age[%0d]", k), 64'(cp_age[k*4 +: 4]), 64'(ex[k]));
                  chk("R3", $sformatf("cp_data[%0d]", k), 64'(cp_data[k*32 +: 32]), 64'(qd[k][m_hit[k]]));
               end else begin
                  chk("R1", $sformatf("cp_age[%0d]", k), 64'(cp_age[k*4 +: 4]), 64'(in_age));
                  chk("R1", $sformatf("cp_data[%0d]", k), 64'(cp_data[k*32 +: 32]), 64'(in_data));
               end
            end
            m_rel[k] = evl && cp_ready[k];
         end
         d = int'(in_dest);
         if (flush) begin
            erdy = 1'b0; tg = "R6";
         end else if (m_bufm[d]) begin
            erdy = order_en[d] && (qa[d].size() < DP);
            tg = !order_en[d] ? "R7" : ((qa[d].size() >= DP) ? "R5" : "R3");
         end else begin
            erdy = cp_ready[d]; tg = "R2";
         end
         chk(tg, "in_ready", 64'(in_ready), 64'(erdy));
         m_take = in_valid && erdy;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            qa[k].delete(); qd[k].delete(); ex[k] = 0; m_rel[k] = 1'b0;
         end
         m_take = 1'b0;
      end else if (flush) begin
         for (int k = 0; k < 2; k++) begin
            qa[k].delete(); qd[k].delete(); ex[k] = int'(restart_age[k*4 +: 4]);
         end
      end else begin
         for (int k = 0; k < 2; k++) begin
            if (m_rel[k] && m_bufm[k]) begin
               qa[k].delete(m_hit[k]); qd[k].delete(m_hit[k]);
               ex[k] = (ex[k] + 1) % 16;     // R4: wraps at the tag range
            end
         end
         if (m_take && m_bufm[int'(in_dest)]) begin
            qa[int'(in_dest)].push_back(int'(in_age));
            qd[int'(in_dest)].push_back(in_data);
         end
      end
   end

   task automatic send(int d, int a, logic [31:0] v);
      bit ok;
      int guard;
      in_valid = 1'b1; in_dest = 1'(d); in_age = 4'(a); in_data = v;
      guard = 0;
      do begin
         #2; ok = in_ready;
         @(negedge clk);
         guard++;
      end while (!ok && guard < 200);
      in_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_flush(logic [3:0] r0, logic [3:0] r1);
      restart_age = {r1, r0}; flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R10: idle after reset
      chk("R10", "cp_valid after reset", 64'(cp_valid), 64'(0));
      @(negedge clk);

      // R2/R1: pass-through on lane 0, out-of-order ages kept in arrival order
      cp_ready = 2'b11;
      send(0, 3, 32'hA003);
      send(0, 1, 32'hA001);
      send(0, 2, 32'hA002);
      // R2: stall from the coprocessor holds in_ready low
      in_valid = 1'b1; in_dest = 1'b0; in_age = 4'd7; in_data = 32'hA007; cp_ready[0] = 1'b0;
      idle(2);
      cp_ready[0] = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;

      // R10: lane 1 starts at age 0 in order mode
      order_en[1] = 1'b1;
      send(1, 0, 32'hB000);
      idle(2);

      // R3: ordered delivery of reversed ages
      do_flush(4'd0, 4'd5);
      send(1, 7, 32'hB007);
      send(1, 6, 32'hB006);
      send(1, 5, 32'hB005);
      idle(4);

      // R4: wrap around the top of the age range
      do_flush(4'd0, 4'd14);
      cp_ready[1] = 1'b0;
      send(1, 1, 32'hB101);
      send(1, 0, 32'hB100);
      send(1, 15, 32'hB10F);
      send(1, 14, 32'hB10E);
      #2;
      chk("R4", "first of wrap run", 64'(cp_age[7:4]), 64'(14));
      @(negedge clk);
      cp_ready[1] = 1'b1;
      idle(6);

      // R5/R8: fill lane 1 while its coprocessor stalls (expected age now 2)
      cp_ready[1] = 1'b0;
      for (int a = 2; a < 10; a++) send(1, a, 32'hC000 + 32'(a));
      in_valid = 1'b1; in_dest = 1'b1; in_age = 4'd10; in_data = 32'hC00A;
      #2;
      chk("R5", "in_ready when full", 64'(in_ready), 64'(0));
      chk("R8", "held age", 64'(cp_age[7:4]), 64'(2));
      @(negedge clk);
      #2;
      chk("R8", "held data", 64'(cp_data[63:32]), 64'(32'hC002));
      @(negedge clk);
      in_valid = 1'b0;
      // R9: lane 0 still passes while lane 1 is full
      in_valid = 1'b1; in_dest = 1'b0; in_age = 4'd9; in_data = 32'hA009;
      #2;
      chk("R9", "lane0 pass while lane1 full", 64'(cp_valid[0]), 64'(1));
      chk("R9", "lane0 ready while lane1 full", 64'(in_ready), 64'(1));
      @(negedge clk);
      in_valid = 1'b0;
      cp_ready[1] = 1'b1;
      idle(10);

      // R7: turn ordering off with entries left (expected age 10)
      cp_ready[1] = 1'b0;
      send(1, 11, 32'hD00B);
      send(1, 10, 32'hD00A);
      order_en[1] = 1'b0;
      cp_ready[1] = 1'b1;
      send(1, 12, 32'hD00C);
      idle(2);

      // R6: flush with a pending offer
      order_en[1] = 1'b1;
      in_valid = 1'b1; in_dest = 1'b1; in_age = 4'd3; in_data = 32'hE003;
      restart_age = {4'd3, 4'd0}; flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      in_valid = 1'b0;
      send(1, 3, 32'hE003);
      idle(2);

      // R9/R3: both lanes ordered, interleaved
      order_en = 2'b11;
      do_flush(4'd0, 4'd0);
      send(0, 1, 32'hF001);
      send(1, 1, 32'hF101);
      send(0, 0, 32'hF000);
      send(1, 0, 32'hF100);
      idle(4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule